// File: doc/BRIEF.md
# Parallel Camera Capture Interface

This block takes pixel samples from an external parallel image sensor and turns them into a stream of 32-bit words for a DMA engine. The sensor side provides up to 14 data lines, a pixel clock, an active-high frame-valid signal and an active-high line-valid signal. Software chooses which pixel-clock edge carries valid data. The pixel clock, the two valid signals and the data are oversampled together in the system clock domain. A sample is taken at the point where the chosen edge shows up in the synchronized copy of the pixel clock.

Samples that the capture window accepts are packed into 32-bit words. In byte mode four samples fill one word. At wider widths two 16-bit halves fill one word. Words leave on a valid/ready stream. Capture can run on every frame or on a single frame. A rectangular crop window can be applied. In JPEG mode the line structure is ignored and the block packs a plain byte stream that is bounded by the frame-valid signal.

Top module: `cam_capture`

## Requirements
- R1: After reset `tvalid_o`, `overrun_o` and `active_o` are low.
- R2: With `fall_edge_i` low, a sample is taken on the rising pixel-clock edge. With it high, a sample is taken on the falling edge. The pixel-clock period is at least 2.5 system clock periods, and data is stable around the chosen edge.
- R3: When `width_i` is 0 (8 bits), four samples form one word. The first sample goes in bits 7:0 and the fourth in bits 31:24.
- R4: When `width_i` is 1, 2 or 3 (10, 12 or 14 bits), two samples form one word. Each sample sits in a 16-bit half, with the first in bits 15:0. Data bits above the selected width read as zero.
- R5: Capture starts only on a rising edge of frame-valid while `enable_i` is high. If `enable_i` rises in the middle of a frame, nothing is captured until the next frame. While `enable_i` is low, `active_o` is low.
- R6: In continuous mode (`snapshot_i` low), every frame that starts while enabled is captured.
- R7: In snapshot mode (`snapshot_i` high), exactly one frame is captured. After that, no capture takes place until `enable_i` has been low.
- R8: Crop window. The pixel index is counted from 0 each time line-valid rises. The line index is counted from 0 at frame start and steps on each fall of line-valid. With `crop_en_i` high, a pixel is kept only when crop_x ≤ pixel < crop_x+crop_w and crop_y ≤ line < crop_y+crop_h.
- R9: With `jpeg_i` high, every sample taken while line-valid is high is kept, and the crop window is ignored. Only bits 7:0 are packed, four per word, whatever `width_i` is.
- R10: While `tvalid_o` is high and `tready_i` is low, `tvalid_o` stays high and `tdata_o` stays stable.
- R11: If a word completes while the output still holds an unaccepted word, the new word is dropped and `overrun_o` goes high. No further words from that frame are produced. `overrun_o` clears and capture resumes at the next captured frame start.
- R12: A partly filled word that remains at the end of a frame is discarded. The next frame starts packing from an empty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pclk_i | input | 1 | Sensor pixel clock |
| vsync_i | input | 1 | Frame valid, active high |
| hsync_i | input | 1 | Line valid, active high |
| pix_i | input | DW | Sensor data lines |
| enable_i | input | 1 | Capture enable |
| snapshot_i | input | 1 | 1 = one frame, 0 = continuous |
| jpeg_i | input | 1 | Compressed byte-stream mode |
| fall_edge_i | input | 1 | 1 = sample on falling pixel-clock edge |
| width_i | input | 2 | 0/1/2/3 = 8/10/12/14-bit samples |
| crop_en_i | input | 1 | Crop window enable |
| crop_x_i | input | CW | First kept pixel in a line |
| crop_y_i | input | CW | First kept line in a frame |
| crop_w_i | input | CW | Pixels kept per line |
| crop_h_i | input | CW | Lines kept per frame |
| tdata_o | output | 32 | Packed word |
| tvalid_o | output | 1 | Word valid |
| tready_i | input | 1 | Downstream ready |
| overrun_o | output | 1 | Word dropped in the current frame |
| active_o | output | 1 | A frame is being captured |

## Verification
Several faults show up as a wrong byte position or a word that is missing or extra, and they appear at the very next word handshake after the frame in question. These are a wrong position in the packing counter, a crop counter that is off by one, or the wrong pixel-clock edge. A capture state machine that fails to stop after a snapshot, or that starts in the middle of a frame, shows up at the end of the following frame as extra or missing words and as the level on `active_o`. A lost overrun block shows up as words that should have been dropped arriving once ready returns.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_10 = 2'd1,
    WID_12 = 2'd2,
    WID_14 = 2'd3
  } width_e;
endpackage

// File: rtl/cam_sync.sv
module cam_sync #(
  parameter int DW     = 14,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  logic          vs_i,
  input  logic          hs_i,
  input  logic [DW-1:0] data_i,
  input  logic          fall_i,
  output logic          stb_o,
  output logic          vs_o,
  output logic          hs_o,
  output logic [DW-1:0] data_o,
  output logic          vs_rise_o,
  output logic          vs_fall_o,
  output logic          hs_fall_o
);
  localparam int VW = DW + 3;

  logic [VW-1:0] pipe_q [STAGES];
  logic [VW-1:0] last_q;
  logic [VW-1:0] cur;

  // data travels with the pixel clock so the edge and its sample stay aligned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      last_q <= '0;
    end else begin
      pipe_q[0] <= {pclk_i, vs_i, hs_i, data_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      last_q <= pipe_q[STAGES-1];
    end
  end

  assign cur       = pipe_q[STAGES-1];
  assign stb_o     = fall_i ? (last_q[VW-1] & ~cur[VW-1]) : (~last_q[VW-1] & cur[VW-1]);
  assign vs_o      = cur[VW-2];
  assign hs_o      = cur[VW-3];
  assign data_o    = cur[DW-1:0];
  assign vs_rise_o = cur[VW-2] & ~last_q[VW-2];
  assign vs_fall_o = ~cur[VW-2] & last_q[VW-2];
  assign hs_fall_o = ~cur[VW-3] & last_q[VW-3];
endmodule

// File: rtl/cam_window.sv
module cam_window #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stb_i,
  input  logic          vs_i,
  input  logic          hs_i,
  input  logic          vs_rise_i,
  input  logic          vs_fall_i,
  input  logic          hs_fall_i,
  input  logic          enable_i,
  input  logic          snapshot_i,
  input  logic          jpeg_i,
  input  logic          crop_en_i,
  input  logic [CW-1:0] crop_x_i,
  input  logic [CW-1:0] crop_y_i,
  input  logic [CW-1:0] crop_w_i,
  input  logic [CW-1:0] crop_h_i,
  input  logic          block_i,
  output logic          accept_o,
  output logic          restart_o,
  output logic          active_o
);
  logic          active_q, done_q;
  logic [CW-1:0] px_q, ln_q;
  logic [CW:0]   px_e, ln_e, x_end, y_end;
  logic          in_x, in_y, in_win;

  assign restart_o = vs_rise_i & enable_i & ~done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (!enable_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (restart_o) begin
      active_q <= 1'b1;
    end else if (vs_fall_i && active_q) begin
      active_q <= 1'b0;
      done_q   <= snapshot_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_q <= '0;
      ln_q <= '0;
    end else begin
      if (!hs_i || vs_rise_i)   px_q <= '0;
      else if (stb_i && vs_i)   px_q <= px_q + 1'b1;
      if (vs_rise_i)            ln_q <= '0;
      else if (hs_fall_i && vs_i) ln_q <= ln_q + 1'b1;
    end
  end

  assign px_e   = {1'b0, px_q};
  assign ln_e   = {1'b0, ln_q};
  assign x_end  = {1'b0, crop_x_i} + {1'b0, crop_w_i};
  assign y_end  = {1'b0, crop_y_i} + {1'b0, crop_h_i};
  assign in_x   = (px_q >= crop_x_i) && (px_e < x_end);
  assign in_y   = (ln_q >= crop_y_i) && (ln_e < y_end);
  assign in_win = ~crop_en_i | jpeg_i | (in_x & in_y);

  assign accept_o = active_q & stb_i & vs_i & hs_i & in_win & ~block_i;
  assign active_o = active_q;
endmodule

// File: rtl/cam_pack.sv
module cam_pack #(
  parameter int DW = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             accept_i,
  input  logic [DW-1:0]    data_i,
  input  cam_pkg::width_e  width_i,
  input  logic             jpeg_i,
  input  logic             tready_i,
  output logic [31:0]      tdata_o,
  output logic             tvalid_o,
  output logic             drop_o
);
  import cam_pkg::*;

  logic [31:0] acc_q, nxt, tdata_q;
  logic [1:0]  cnt_q;
  logic        tvalid_q, byte_mode, last, word_done, free;
  logic [4:0]  nbits;
  logic [15:0] samp;

  always_comb begin
    byte_mode = jpeg_i || (width_i == WID_8);
    nbits     = byte_mode ? 5'd8 : 5'(8 + 2 * int'(width_i));
    samp      = 16'(data_i) & ((16'd1 << nbits) - 16'd1);
    nxt       = acc_q;
    if (byte_mode)     nxt[8*cnt_q +: 8] = samp[7:0];
    else if (cnt_q[0]) nxt[31:16]        = samp;
    else               nxt[15:0]         = samp;
    last      = byte_mode ? (cnt_q == 2'd3) : cnt_q[0];
  end

  assign word_done = accept_i & last;
  assign free      = ~tvalid_q | tready_i;
  assign drop_o    = word_done & ~free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (accept_i) begin
      acc_q <= nxt;
      cnt_q <= last ? 2'd0 : cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdata_q  <= '0;
      tvalid_q <= 1'b0;
    end else if (word_done && free) begin
      tdata_q  <= nxt;
      tvalid_q <= 1'b1;
    end else if (tvalid_q && tready_i) begin
      tvalid_q <= 1'b0;
    end
  end

  assign tdata_o  = tdata_q;
  assign tvalid_o = tvalid_q;
endmodule

// File: rtl/cam_capture.sv
module cam_capture #(
  parameter int DW     = 14,
  parameter int CW     = 12,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  logic          vsync_i,
  input  logic          hsync_i,
  input  logic [DW-1:0] pix_i,
  input  logic          enable_i,
  input  logic          snapshot_i,
  input  logic          jpeg_i,
  input  logic          fall_edge_i,
  input  logic [1:0]    width_i,
  input  logic          crop_en_i,
  input  logic [CW-1:0] crop_x_i,
  input  logic [CW-1:0] crop_y_i,
  input  logic [CW-1:0] crop_w_i,
  input  logic [CW-1:0] crop_h_i,
  output logic [31:0]   tdata_o,
  output logic          tvalid_o,
  input  logic          tready_i,
  output logic          overrun_o,
  output logic          active_o
);
  logic          stb, vs, hs, vs_rise, vs_fall, hs_fall;
  logic [DW-1:0] data;
  logic          accept, restart, drop, ovr_q;
  cam_pkg::width_e width;

  assign width = cam_pkg::width_e'(width_i);

  cam_sync #(.DW(DW), .STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .pclk_i, .vs_i(vsync_i), .hs_i(hsync_i), .data_i(pix_i),
    .fall_i(fall_edge_i), .stb_o(stb), .vs_o(vs), .hs_o(hs), .data_o(data),
    .vs_rise_o(vs_rise), .vs_fall_o(vs_fall), .hs_fall_o(hs_fall)
  );

  cam_window #(.CW(CW)) u_win (
    .clk_i, .rst_ni, .stb_i(stb), .vs_i(vs), .hs_i(hs), .vs_rise_i(vs_rise),
    .vs_fall_i(vs_fall), .hs_fall_i(hs_fall), .enable_i, .snapshot_i, .jpeg_i,
    .crop_en_i, .crop_x_i, .crop_y_i, .crop_w_i, .crop_h_i, .block_i(ovr_q),
    .accept_o(accept), .restart_o(restart), .active_o
  );

  cam_pack #(.DW(DW)) u_pack (
    .clk_i, .rst_ni, .restart_i(restart), .accept_i(accept), .data_i(data),
    .width_i(width), .jpeg_i, .tready_i, .tdata_o, .tvalid_o, .drop_o(drop)
  );

  // blocks the rest of the frame once a word was lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_q <= 1'b0;
    else if (restart) ovr_q <= 1'b0;
    else if (drop)    ovr_q <= 1'b1;
  end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        snapshot_i,
  input logic [31:0] tdata_o,
  input logic        tvalid_o,
  input logic        tready_i,
  input logic        overrun_o,
  input logic        active_o
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tvalid_o && !tready_i |=> tvalid_o && $stable(tdata_o));

  p_word_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tvalid_o) |-> $past(active_o));

  p_idle_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !active_o);

  p_ovr_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(tvalid_o && !tready_i));

  p_ovr_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(overrun_o) |-> active_o);

  p_snap_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && snapshot_i && $past(enable_i && snapshot_i) && $fell(active_o) |=> !active_o);
endmodule

bind cam_capture cam_capture_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .snapshot_i(snapshot_i),
  .tdata_o(tdata_o), .tvalid_o(tvalid_o), .tready_i(tready_i),
  .overrun_o(overrun_o), .active_o(active_o)
);

// File: tb/tb_cam_capture.sv
module tb_cam_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pclk = 1'b0, vs = 1'b0, hs = 1'b0;
  logic [13:0] pix = '0;
  logic        enable = 1'b0, snapshot = 1'b0, jpeg = 1'b0, fall = 1'b0, crop_en = 1'b0;
  logic [1:0]  width = 2'd0;
  logic [11:0] cx = '0, cy = '0, cw = '0, ch = '0;
  logic        tready = 1'b1;
  logic [31:0] tdata_o;
  logic        tvalid_o, overrun_o, active_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] got[$];
  logic [31:0] exp[$];

  always #2 clk = ~clk;

  cam_capture dut (
    .clk_i(clk), .rst_ni(rst_n), .pclk_i(pclk), .vsync_i(vs), .hsync_i(hs), .pix_i(pix),
    .enable_i(enable), .snapshot_i(snapshot), .jpeg_i(jpeg), .fall_edge_i(fall),
    .width_i(width), .crop_en_i(crop_en), .crop_x_i(cx), .crop_y_i(cy), .crop_w_i(cw),
    .crop_h_i(ch), .tdata_o(tdata_o), .tvalid_o(tvalid_o), .tready_i(tready),
    .overrun_o(overrun_o), .active_o(active_o)
  );

  always @(negedge clk) if (rst_n && tvalid_o && tready) got.push_back(tdata_o);

  function automatic logic [13:0] va(int l, int p, int s);
    return 14'((s * 1009 + l * 211 + p * 53 + 7) * 37) ^ 14'h2C35;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic cmp_stream(input string tag);
    check(got.size() == exp.size(), {tag, " word count"}, got.size(), exp.size());
    for (int i = 0; i < got.size() && i < exp.size(); i++)
      check(got[i] == exp[i], {tag, " word"}, got[i], exp[i]);
    got.delete();
    exp.delete();
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 tready = v;
  endtask

  task automatic cfg(input logic f, input logic [1:0] w, input logic j, input logic ce,
                     input int x, input int y, input int wd, input int h, input logic sn);
    @(negedge clk) enable = 1'b0;
    repeat (3) @(negedge clk);
    fall = f; width = w; jpeg = j; crop_en = ce; snapshot = sn;
    cx = 12'(x); cy = 12'(y); cw = 12'(wd); ch = 12'(h);
    @(negedge clk) enable = 1'b1;
    repeat (3) @(negedge clk);
    got.delete();
    exp.delete();
  endtask

  // one pixel: a is stable around the rising edge, ~a around the falling edge
  task automatic pixel(input logic [13:0] a);
    @(negedge clk) pix = a;
    repeat (2) @(negedge clk);
    pclk = 1'b1;
    repeat (3) @(negedge clk);
    pix = ~a;
    @(negedge clk) pclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input int nl, input int np, input int seed, input bit cap);
    logic [31:0] acc;
    int          cnt;
    logic [13:0] s;
    logic [15:0] mask;
    bit          take;
    acc = '0; cnt = 0;
    mask = 16'((32'd1 << (8 + 2 * int'(width))) - 1);
    @(negedge clk) vs = 1'b1;
    repeat (4) @(negedge clk);
    for (int l = 0; l < nl; l++) begin
      @(negedge clk) hs = 1'b1;
      repeat (2) @(negedge clk);
      for (int p = 0; p < np; p++) begin
        pixel(va(l, p, seed));
        take = jpeg || !crop_en ||
               (p >= int'(cx) && p < int'(cx) + int'(cw) && l >= int'(cy) && l < int'(cy) + int'(ch));
        s = fall ? ~va(l, p, seed) : va(l, p, seed);
        if (cap && take) begin
          if (jpeg || width == 2'd0) begin
            acc[8*cnt +: 8] = s[7:0];
            cnt++;
            if (cnt == 4) begin exp.push_back(acc); cnt = 0; end
          end else begin
            acc[16*cnt +: 16] = 16'(s) & mask;
            cnt++;
            if (cnt == 2) begin exp.push_back(acc); cnt = 0; end
          end
        end
      end
      @(negedge clk) hs = 1'b0;
      repeat (3) @(negedge clk);
    end
    @(negedge clk) vs = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    check(tvalid_o == 1'b0, "R1 tvalid after reset", tvalid_o, 0);
    check(overrun_o == 1'b0, "R1 overrun after reset", overrun_o, 0);
    check(active_o == 1'b0, "R1 active after reset", active_o, 0);
  endtask

  task automatic t_pack8;
    logic [13:0] a0;
    cfg(0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    frame(2, 4, 1, 1);
    frame(1, 8, 2, 1);
    a0 = va(0, 0, 1);
    if (got.size() > 0) check(got[0][7:0] == a0[7:0], "R3 first sample in low byte", got[0][7:0], a0[7:0]);
    else check(0, "R3 first sample in low byte", 0, a0[7:0]);
    cmp_stream("R3 R6 R2 byte packing, continuous, rising edge");
  endtask

  task automatic t_wide;
    logic [13:0] a0;
    cfg(0, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    frame(1, 4, 3, 1);
    a0 = va(0, 0, 3);
    if (got.size() > 0) check(got[0][15:0] == {4'h0, a0[11:0]}, "R4 12-bit zero extension", got[0][15:0], {4'h0, a0[11:0]});
    else check(0, "R4 12-bit zero extension", 0, a0[11:0]);
    cmp_stream("R4 12-bit halves");
    cfg(0, 2'd3, 0, 0, 0, 0, 0, 0, 0);
    frame(2, 2, 4, 1);
    cmp_stream("R4 14-bit halves");
  endtask

  task automatic t_fall;
    logic [13:0] b0;
    cfg(1, 2'd3, 0, 0, 0, 0, 0, 0, 0);
    frame(1, 4, 5, 1);
    b0 = ~va(0, 0, 5);
    if (got.size() > 0) check(got[0][13:0] == b0, "R2 falling edge sample", got[0][13:0], b0);
    else check(0, "R2 falling edge sample", 0, b0);
    cmp_stream("R2 falling edge stream");
  endtask

  task automatic t_crop;
    cfg(0, 2'd0, 0, 1, 2, 1, 4, 2, 0);
    frame(4, 8, 6, 1);
    check(exp.size() == 2, "R8 model window size", exp.size(), 2);
    cmp_stream("R8 crop window");
  endtask

  task automatic t_jpeg;
    cfg(0, 2'd3, 1, 1, 1, 1, 1, 1, 0);
    frame(3, 4, 7, 1);
    cmp_stream("R9 jpeg bytes ignore crop and width");
  endtask

  task automatic t_snapshot;
    cfg(0, 2'd0, 0, 0, 0, 0, 0, 0, 1);
    frame(1, 8, 8, 1);
    frame(1, 8, 9, 0);
    check(active_o == 1'b0, "R7 idle after snapshot", active_o, 0);
    cmp_stream("R7 snapshot single frame");
  endtask

  task automatic t_late;
    cfg(0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk) enable = 1'b0;
    fork
      frame(2, 4, 10, 0);
      begin repeat (40) @(negedge clk); enable = 1'b1; end
    join
    check(active_o == 1'b0, "R5 no start mid-frame", active_o, 0);
    frame(1, 4, 11, 1);
    cmp_stream("R5 capture from next frame start");
  endtask

  task automatic t_overrun;
    logic [31:0] w0;
    cfg(0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    set_ready(1'b0);
    frame(1, 12, 12, 0);
    w0 = {va(0, 3, 12)[7:0], va(0, 2, 12)[7:0], va(0, 1, 12)[7:0], va(0, 0, 12)[7:0]};
    check(overrun_o == 1'b1, "R11 overrun flagged", overrun_o, 1);
    check(tvalid_o == 1'b1 && tdata_o == w0, "R10 word held while not ready", tdata_o, w0);
    set_ready(1'b1);
    repeat (5) @(negedge clk);
    exp.push_back(w0);
    cmp_stream("R11 later words of frame dropped");
    frame(1, 8, 13, 1);
    check(overrun_o == 1'b0, "R11 overrun cleared at next frame", overrun_o, 0);
    cmp_stream("R11 capture resumes");
  endtask

  task automatic t_partial;
    cfg(0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    frame(1, 6, 14, 1);
    frame(1, 4, 15, 1);
    cmp_stream("R12 partial word discarded");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_pack8();
    t_wide();
    t_fall();
    t_crop();
    t_jpeg();
    t_snapshot();
    t_late();
    t_overrun();
    t_partial();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule